// File: doc/BRIEF.md
# MDIO Management Slave

This block is the serial side of a management port for a single PHY. It samples the MDIO data line on each rising edge of the management clock. It recognises the start pattern and collects the opcode and address header. It then either returns sixteen bits of register data or collects sixteen bits of write data. A register file attaches to a plain parallel port. That port carries the register address, a read strobe with a read-data input, and a write strobe with write data.

The line is modelled as three separate signals: a sampled input, an output value and an output enable. The pad, or the surrounding logic, merges them. The PHY-address field of every frame is ignored, so each frame is treated as addressed to this device. In the read turnaround, the slave drives the line low for both bit times.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: An active-high synchronous reset returns the slave to idle. While reset is applied and after it is released, `mdio_oe`, `rd_stb` and `wr_stb` are low.
- R2: While idle, high bits are ignored. The first low bit arms the slave. Further low bits keep it armed, and the next high bit begins the header.
- R3: The header is 12 bits, each sent most significant bit first, in this order: a 2-bit opcode, a 5-bit PHY address, then a 5-bit register address. The PHY address has no effect on the frame, and the register address appears on `reg_addr`.
- R4: Opcode 10 selects a read and opcode 01 selects a write. Opcodes 00 and 11 abandon the frame and return to idle. An abandoned frame produces no strobe and never enables the output.
- R5: `mdio_oe` goes high with `mdio_o` = 0 in the cycle after the last header bit of a read is sampled. Both hold for the two turnaround bit times.
- R6: In the second turnaround cycle of a read, `rd_stb` is high for exactly one cycle with `reg_addr` valid. `rd_data` is captured at the clock edge that ends that cycle.
- R7: The 16 captured read bits appear on `mdio_o` most significant bit first, one bit per clock, with `mdio_oe` high. After the last bit `mdio_oe` falls and the slave is idle again.
- R8: For a write, the two turnaround bits are ignored and 16 data bits are sampled most significant bit first. In the cycle after the 16th data bit is sampled, `wr_stb` is high for exactly one cycle with `reg_addr` and `wr_data` holding the frame's values.
- R9: `mdio_oe` stays low throughout idle, write frames and abandoned frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; the line is sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mdio_i | input | 1 | Sampled level of the data line |
| mdio_o | output | 1 | Value driven onto the data line |
| mdio_oe | output | 1 | High while the slave drives the line |
| reg_addr | output | 5 | Register address from the latest header |
| wr_data | output | 16 | Data collected by the latest write frame |
| wr_stb | output | 1 | One-cycle write request |
| rd_stb | output | 1 | One-cycle read request |
| rd_data | input | 16 | Register value returned for a read |

## Verification
All outputs are registered or decoded from registered state, so each result is visible in the cycle after the clock edge that samples the bit causing it. The turnaround drive follows the last header bit by one cycle. The read strobe follows it by two cycles. The first read bit follows it by three cycles, and each later read bit comes one cycle after the one before. The write strobe follows the 16th data bit by one cycle. The bench drives each line bit at the falling edge and checks every output 1 ns after the next rising edge. It compares each cycle against the result due for that bit's position in the frame, so any result that arrives one cycle early or late is reported.

// File: rtl/mdio_mgmt_pkg.sv
`timescale 1ns/1ps
package mdio_mgmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_HDR, ST_TA_RD, ST_TA_WR, ST_RD, ST_WR
  } mdio_state_e;

  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] OPC_WRITE = 2'b01;

  function automatic logic op_is_read(input logic [1:0] op);
    return op == OPC_READ;
  endfunction

  function automatic logic op_is_write(input logic [1:0] op);
    return op == OPC_WRITE;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mdio_rx_shifter.sv
`timescale 1ns/1ps
module mdio_rx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] nxt
);
  logic [W-1:0] q;

  assign nxt = {q[W-2:0], din};

  always_ff @(posedge clk) begin
    if (en) q <= nxt;
  end
endmodule

// File: rtl/mdio_tx_shifter.sv
`timescale 1ns/1ps
module mdio_tx_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] q;

  assign msb = q[W-1];

  always_ff @(posedge clk) begin
    if (rst)        q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
  import mdio_mgmt_pkg::*;
#(
  parameter int HDR_W  = 12,
  parameter int TA_W   = 2,
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        mdio_i,
  input  logic [1:0]  hdr_op,
  output mdio_state_e state,
  output logic        hdr_done,
  output logic        ta_last,
  output logic        data_last
);
  localparam int CNT_MAX = max_of(max_of(HDR_W, DATA_W), TA_W);
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic [CNT_W-1:0] cnt;
  mdio_state_e      nxt_state;

  assign hdr_done  = (state == ST_HDR) && (cnt == CNT_W'(HDR_W - 1));
  assign ta_last   = ((state == ST_TA_RD) || (state == ST_TA_WR)) && (cnt == CNT_W'(TA_W - 1));
  assign data_last = ((state == ST_RD) || (state == ST_WR)) && (cnt == CNT_W'(DATA_W - 1));

  always_comb begin
    nxt_state = state;
    unique case (state)
      ST_IDLE:  if (!mdio_i) nxt_state = ST_START;
      ST_START: if (mdio_i)  nxt_state = ST_HDR;
      ST_HDR:   if (hdr_done) begin
        if (op_is_read(hdr_op))       nxt_state = ST_TA_RD;
        else if (op_is_write(hdr_op)) nxt_state = ST_TA_WR;
        else                          nxt_state = ST_IDLE;
      end
      ST_TA_RD: if (ta_last) nxt_state = ST_RD;
      ST_TA_WR: if (ta_last) nxt_state = ST_WR;
      ST_RD, ST_WR: if (data_last) nxt_state = ST_IDLE;
      default:  nxt_state = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt_state;
      if (nxt_state != state) cnt <= '0;
      else if (state inside {ST_HDR, ST_TA_RD, ST_TA_WR, ST_RD, ST_WR}) cnt <= cnt + 1'b1;
    end
  end

  // R2: a low bit seen while idle arms the slave
  p_arm_on_low_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !mdio_i) |=> (state == ST_START));

  // R4: an unknown opcode abandons the frame
  p_bad_op_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (hdr_done && !op_is_read(hdr_op) && !op_is_write(hdr_op)) |=> (state == ST_IDLE));
endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int PHY_AW = 5,
  parameter int REG_AW = 5,
  parameter int DATA_W = 16,
  parameter int TA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_stb,
  output logic              rd_stb,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int OP_W  = 2;
  localparam int HDR_W = OP_W + PHY_AW + REG_AW;
  localparam int SR_W  = max_of(HDR_W, DATA_W);

  mdio_state_e     state;
  logic            hdr_done, ta_last, data_last;
  logic [SR_W-1:0] rx_nxt;
  logic [1:0]      hdr_op;
  logic            tx_msb;
  logic            rx_en;

  assign hdr_op = rx_nxt[HDR_W-1 -: OP_W];
  assign rx_en  = (state == ST_HDR) || (state == ST_WR);

  mdio_frame_fsm #(.HDR_W(HDR_W), .TA_W(TA_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .hdr_op(hdr_op),
    .state(state), .hdr_done(hdr_done), .ta_last(ta_last), .data_last(data_last)
  );

  mdio_rx_shifter #(.W(SR_W)) u_rx (
    .clk(clk), .en(rx_en), .din(mdio_i), .nxt(rx_nxt)
  );

  assign rd_stb = (state == ST_TA_RD) && ta_last;

  mdio_tx_shifter #(.W(DATA_W)) u_tx (
    .clk(clk), .rst(rst), .load(rd_stb), .shift(state == ST_RD),
    .din(rd_data), .msb(tx_msb)
  );

  assign mdio_oe = (state == ST_TA_RD) || (state == ST_RD);
  assign mdio_o  = (state == ST_RD) ? tx_msb : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_addr <= '0;
      wr_data  <= '0;
      wr_stb   <= 1'b0;
    end else begin
      if (hdr_done) reg_addr <= rx_nxt[REG_AW-1:0];
      wr_stb <= (state == ST_WR) && data_last;
      if ((state == ST_WR) && data_last) wr_data <= rx_nxt[DATA_W-1:0];
    end
  end

  // R5: the drive starts right after the header and starts low
  p_oe_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(mdio_oe) |-> ($past(hdr_done) && !mdio_o));

  // R6: the fetch is followed by data drive with a steady address
  p_fetch_then_drive_r6: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> (mdio_oe && $stable(reg_addr) && !rd_stb));

  // R7: the drive ends after the last read bit
  p_rd_end_r7: assert property (@(posedge clk) disable iff (rst)
    (data_last && state == ST_RD) |=> !mdio_oe);

  // R8: the write strobe is a single pulse following the last data bit
  p_wr_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);
  p_wr_source_r8: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> $past(data_last && state == ST_WR));

  // R9: a write never enables the output
  p_no_drive_on_write_r9: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !mdio_oe);
endmodule

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mdio_i = 1'b1;
  logic        mdio_o, mdio_oe, wr_stb, rd_stb;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data, rd_data;
  logic [15:0] mem [32];
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  assign rd_data = mem[reg_addr];

  mdio_mgmt_slave uut (
    .clk(clk), .rst(rst), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .reg_addr(reg_addr), .wr_data(wr_data), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .rd_data(rd_data)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    finish_run();
  end

  // e = {oe, o, rd_stb, wr_stb}
  task automatic compare(input logic [3:0] e, input string tag,
                         input bit ca, input logic [4:0] ea,
                         input bit cd, input logic [15:0] ed);
    logic [3:0] a;
    a = {mdio_oe, mdio_o, rd_stb, wr_stb};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: {oe,o,rd,wr} actual=%b expected=%b", tag, a, e);
    end
    if (ca) begin
      checks++;
      if (reg_addr !== ea) begin
        errors++;
        $display("FAIL %s: reg_addr actual=%0d expected=%0d", tag, reg_addr, ea);
      end
    end
    if (cd) begin
      checks++;
      if (wr_data !== ed) begin
        errors++;
        $display("FAIL %s: wr_data actual=%h expected=%h", tag, wr_data, ed);
      end
    end
  endtask

  task automatic step(input logic b, input logic [3:0] e, input string tag,
                      input bit ca = 0, input logic [4:0] ea = '0,
                      input bit cd = 0, input logic [15:0] ed = '0);
    @(negedge clk);
    mdio_i = b;
    @(posedge clk);
    #1;
    compare(e, tag, ca, ea, cd, ed);
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy,
                       input logic [4:0] ra, input logic [15:0] wd,
                       input int pre, input int zs);
    logic [11:0] hdr;
    logic [15:0] rv;
    hdr = {op, phy, ra};
    rv  = mem[ra];
    for (int i = 0; i < pre; i++) step(1'b1, 4'b0000, "R2");
    for (int i = 0; i < zs; i++)  step(1'b0, 4'b0000, "R2");
    step(1'b1, 4'b0000, "R2");
    for (int i = 11; i > 0; i--) step(hdr[i], 4'b0000, "R3");
    if (op == 2'b10) begin
      step(hdr[0], 4'b1000, "R5");
      step(1'b1, 4'b1010, "R6", 1, ra);
      for (int k = 0; k < 16; k++) step(1'b1, {1'b1, rv[15-k], 2'b00}, "R7");
      step(1'b1, 4'b0000, "R7");
    end else if (op == 2'b01) begin
      step(hdr[0], 4'b0000, "R9");
      step(1'b0, 4'b0000, "R8");
      step(1'b1, 4'b0000, "R8");
      for (int k = 0; k < 15; k++) step(wd[15-k], 4'b0000, "R9");
      step(wd[0], 4'b0001, "R8", 1, ra, 1, wd);
      mem[ra] = wd;
    end else begin
      step(hdr[0], 4'b0000, "R4");
    end
    step(1'b1, 4'b0000, "R4");
    step(1'b1, 4'b0000, "R4");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 16'(i * 16'h1357 + 16'h0a0f);
    repeat (3) @(posedge clk);
    #1 compare(4'b0000, "R1", 0, '0, 0, '0);
    @(negedge clk) rst = 1'b0;
    step(1'b1, 4'b0000, "R1");

    frame(2'b10, 5'd0,  5'd3,  16'h0000, 4, 1);   // plain read
    frame(2'b01, 5'd7,  5'd3,  16'hA55A, 2, 1);   // write, odd PHY address
    frame(2'b10, 5'd31, 5'd3,  16'h0000, 1, 3);   // read-back, R3 PHY ignored, R2 extra lows
    frame(2'b01, 5'd0,  5'd31, 16'h8001, 0, 1);   // edge bits in data
    frame(2'b10, 5'd12, 5'd31, 16'h0000, 3, 1);
    frame(2'b00, 5'd1,  5'd5,  16'h0000, 2, 1);   // R4 abandoned
    frame(2'b11, 5'd2,  5'd6,  16'h0000, 2, 1);   // R4 abandoned
    frame(2'b10, 5'd4,  5'd0,  16'h0000, 1, 2);   // R4 recovery

    // R1: reset in the middle of read data
    step(1'b0, 4'b0000, "R2");
    step(1'b1, 4'b0000, "R2");
    for (int i = 11; i > 0; i--) step(i == 11, 4'b0000, "R3");
    step(1'b0, 4'b1000, "R5");
    step(1'b1, 4'b1010, "R6", 1, 5'd0);
    step(1'b1, {1'b1, mem[0][15], 2'b00}, "R7");
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1 compare(4'b0000, "R1", 0, '0, 0, '0);
    @(negedge clk) rst = 1'b0;
    step(1'b1, 4'b0000, "R1");
    step(1'b1, 4'b0000, "R1");
    frame(2'b10, 5'd9, 5'd31, 16'h0000, 2, 1);

    finish_run();
  end
endmodule